// File: doc/BRIEF.md
# Forwarded Register Window Bridge

This block sits behind a host address decoder and serves one reserved address window. A 32-bit host slave access that selects the window goes one of two ways. If it targets the bridge's own interrupt registers it completes locally. Otherwise it is forwarded to an external module over a simple request/acknowledge register bus that has an 8-bit word-aligned address. Only one access is in flight at a time. The host keeps its select and access fields steady until it sees the transfer acknowledge, and it drops select before the next clock edge.

If the external module stays silent, the bridge does not hang the host. A response timer ends the wait and answers with a transfer acknowledge that carries an error acknowledge. The external module may also raise a one-cycle interrupt pulse. The bridge latches that pulse into a status bit, gates the bit with an enable bit to form its interrupt output, and clears it through a separate write-one-to-clear register.

The controller has three states. `ST_IDLE` waits for a host select. `ST_WAIT` holds the external request. `ST_RESP` drives the one-cycle host acknowledge. The transitions are:
- `ST_IDLE`→`ST_WAIT` on a select to a forwarded address.
- `ST_IDLE`→`ST_RESP` on a select to a local register.
- `ST_WAIT`→`ST_RESP` on an external acknowledge, or on the timeout when no acknowledge arrives. The acknowledge wins when both happen in the same cycle.
- `ST_RESP`→`ST_IDLE` unconditionally.

Top module: `fwd_win_bridge`

## Requirements
- R1: After reset, ext_req, host_ack, host_err and irq_out are all 0, and the interrupt status and enable bits are 0.
- R2: A forwarded access drives ext_addr = {host_addr[7:2], 2'b00}, ext_be = host_be, ext_rnw = host_rnw and ext_wdata = host_wdata. These fields, together with ext_req, stay constant until ext_ack is sampled high or the timeout ends the wait.
- R3: ext_req goes low in the cycle after ext_ack is sampled high. Each host access raises ext_req exactly once. For a read, ext_rdata is captured in the acknowledge cycle and returned on host_rdata with host_ack in the next cycle. For a write, host_rdata is 0.
- R4: If ext_ack is not sampled high in any of the 16 cycles ext_req is high, ext_req drops and the host gets host_ack with host_err = 1 and host_rdata = 0.
- R5: An ext_ack sampled in the 16th (last) request cycle completes the access normally, with host_err = 0.
- R6: host_ack is high for exactly one cycle per access, and host_err is high only together with host_ack.
- R7: host_addr[8] = 1 selects the local registers and never raises ext_req. host_addr[3:2] picks the register: 0 is status (bit 0, read-only), 1 is enable (bit 0, read/write), 2 is clear (write-only, reads 0), 3 is reserved (reads 0, writes ignored). All other bits read 0.
- R8: A one-cycle high on irq_pulse sets the status bit. irq_out equals status AND enable.
- R9: Writing 1 to clear-register bit 0 clears the status bit. Writing 0 there has no effect.
- R10: host_be[3] enables the byte lane of host_wdata[7:0], and host_be[0] enables the lane of host_wdata[31:24]. A local write with host_be[3] = 0 changes nothing.
- R11: host_addr[1:0] are ignored and treated as 0 for both local and forwarded accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access to the window |
| host_rnw | input | 1 | 1 = read, 0 = write |
| host_addr | input | 32 | Host byte address |
| host_be | input | 4 | Byte enables, bit 0 = most significant lane |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_ack | output | 1 | Transfer acknowledge |
| host_err | output | 1 | Error acknowledge, only with host_ack |
| ext_req | output | 1 | External request |
| ext_rnw | output | 1 | External read-not-write |
| ext_addr | output | 8 | External word-aligned address |
| ext_be | output | 4 | External byte enables |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data |
| ext_ack | input | 1 | External acknowledge |
| irq_pulse | input | 1 | One-cycle interrupt from external module |
| irq_out | output | 1 | Masked interrupt output |

## Verification
The bench builds the bridge with its default 16-cycle timeout, 32-bit data and 8-bit external address. These values keep the whole timeout window small enough to sweep external response delays from 0 to 20 cycles. That sweep crosses the edge between the last accepted acknowledge and the first timeout. The same build lets random local accesses and interrupt pulses exercise the status, enable and clear interplay on every register offset, including the reserved one.

// File: rtl/fwd_win_pkg.sv
package fwd_win_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } win_state_t;

    localparam int REG_STATUS = 0;
    localparam int REG_ENABLE = 1;
    localparam int REG_CLEAR  = 2;
endpackage

// File: rtl/fwd_win_fsm.sv
module fwd_win_fsm
    import fwd_win_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       is_local,
    input  logic       ext_ack,
    input  logic       tmo_hit,
    output win_state_t state,
    output logic       accept_ext,
    output logic       accept_loc,
    output logic       ext_done,
    output logic       ext_tmo
);
    win_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt        = state;
        accept_ext = 1'b0;
        accept_loc = 1'b0;
        ext_done   = 1'b0;
        ext_tmo    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (host_sel) begin
                    if (is_local) begin
                        accept_loc = 1'b1;
                        nxt        = ST_RESP;
                    end else begin
                        accept_ext = 1'b1;
                        nxt        = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (ext_ack) begin
                    ext_done = 1'b1;
                    nxt      = ST_RESP;
                end else if (tmo_hit) begin
                    ext_tmo = 1'b1;
                    nxt     = ST_RESP;
                end
            end
            ST_RESP: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/fwd_win_timer.sv
module fwd_win_timer #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign hit = run && (cnt == LAST);
endmodule

// File: rtl/fwd_win_irq.sv
module fwd_win_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic en_wr,
    input  logic en_val,
    input  logic clr_wr,
    input  logic clr_val,
    output logic status,
    output logic enable,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= 1'b0;
            enable <= 1'b0;
        end else begin
            if (pulse)                 status <= 1'b1;
            else if (clr_wr && clr_val) status <= 1'b0;
            if (en_wr) enable <= en_val;
        end
    end

    assign irq = status & enable;
endmodule

// File: rtl/fwd_win_bridge.sv
module fwd_win_bridge
    import fwd_win_pkg::*;
#(
    parameter int TIMEOUT   = 16,
    parameter int DW        = 32,
    parameter int AW        = 32,
    parameter int EXT_AW    = 8,
    parameter int LOCAL_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_rnw,
    input  logic [AW-1:0]     host_addr,
    input  logic [DW/8-1:0]   host_be,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              host_ack,
    output logic              host_err,
    output logic              ext_req,
    output logic              ext_rnw,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [DW/8-1:0]   ext_be,
    output logic [DW-1:0]     ext_wdata,
    input  logic [DW-1:0]     ext_rdata,
    input  logic              ext_ack,
    input  logic              irq_pulse,
    output logic              irq_out
);
    localparam int BEW  = DW / 8;
    localparam int WSEL = EXT_AW - 2;

    win_state_t state;
    logic accept_ext, accept_loc, ext_done, ext_tmo, tmo_hit;
    logic in_wait, in_resp;
    logic irq_status, irq_enable;
    logic [WSEL-1:0] word_q;
    logic [BEW-1:0]  be_q;
    logic [DW-1:0]   wdata_q, rdata_q, loc_rdata;
    logic            rnw_q, err_q;
    logic [1:0]      loc_idx;
    logic            loc_wr, lane0;

    fwd_win_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .is_local   (host_addr[LOCAL_BIT]),
        .ext_ack    (ext_ack),
        .tmo_hit    (tmo_hit),
        .state      (state),
        .accept_ext (accept_ext),
        .accept_loc (accept_loc),
        .ext_done   (ext_done),
        .ext_tmo    (ext_tmo)
    );

    assign in_wait = (state == ST_WAIT);
    assign in_resp = (state == ST_RESP);

    fwd_win_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_wait),
        .hit   (tmo_hit)
    );

    assign loc_idx = host_addr[3:2];
    assign loc_wr  = accept_loc && !host_rnw;
    assign lane0   = host_be[BEW-1];

    fwd_win_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse   (irq_pulse),
        .en_wr   (loc_wr && lane0 && (loc_idx == 2'(REG_ENABLE))),
        .en_val  (host_wdata[0]),
        .clr_wr  (loc_wr && lane0 && (loc_idx == 2'(REG_CLEAR))),
        .clr_val (host_wdata[0]),
        .status  (irq_status),
        .enable  (irq_enable),
        .irq     (irq_out)
    );

    always_comb begin
        loc_rdata = '0;
        unique case (loc_idx)
            2'(REG_STATUS): loc_rdata[0] = irq_status;
            2'(REG_ENABLE): loc_rdata[0] = irq_enable;
            default:        loc_rdata    = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            rnw_q   <= 1'b0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (accept_ext) begin
                word_q  <= host_addr[EXT_AW-1:2];
                be_q    <= host_be;
                wdata_q <= host_wdata;
                rnw_q   <= host_rnw;
                err_q   <= 1'b0;
            end
            if (accept_loc) begin
                rdata_q <= host_rnw ? loc_rdata : '0;
                err_q   <= 1'b0;
            end
            if (ext_done) rdata_q <= rnw_q ? ext_rdata : '0;
            if (ext_tmo) begin
                rdata_q <= '0;
                err_q   <= 1'b1;
            end
        end
    end

    assign ext_req    = in_wait;
    assign ext_rnw    = rnw_q;
    assign ext_addr   = {word_q, 2'b00};
    assign ext_be     = be_q;
    assign ext_wdata  = wdata_q;
    assign host_ack   = in_resp;
    assign host_err   = in_resp && err_q;
    assign host_rdata = in_resp ? rdata_q : '0;
endmodule

// File: rtl/fwd_win_chk.sv
module fwd_win_chk #(
    parameter int TIMEOUT = 16,
    parameter int DW      = 32,
    parameter int EXT_AW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ack,
    input logic              host_err,
    input logic [DW-1:0]     host_rdata,
    input logic              ext_req,
    input logic              ext_ack,
    input logic              ext_rnw,
    input logic [EXT_AW-1:0] ext_addr,
    input logic [DW/8-1:0]   ext_be,
    input logic [DW-1:0]     ext_wdata,
    input logic              irq_pulse,
    input logic              irq_en,
    input logic              irq_out
);
    localparam int CW = $clog2(TIMEOUT + 1);
    logic [CW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !ext_req) wait_cnt <= '0;
        else if (wait_cnt != CW'(TIMEOUT)) wait_cnt <= wait_cnt + 1'b1;
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack && (wait_cnt < CW'(TIMEOUT - 1))) |=>
        (ext_req && $stable(ext_addr) && $stable(ext_be) && $stable(ext_rnw) && $stable(ext_wdata)));

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ext_ack) |=> !ext_req);

    // R4
    tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> (wait_cnt < CW'(TIMEOUT)));

    // R4
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> (host_rdata == '0));

    // R6
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |-> host_ack);

    // R6
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);

    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && irq_en) |=> irq_out);
endmodule

bind fwd_win_bridge fwd_win_chk #(.TIMEOUT(TIMEOUT), .DW(DW), .EXT_AW(EXT_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ack   (host_ack),
    .host_err   (host_err),
    .host_rdata (host_rdata),
    .ext_req    (ext_req),
    .ext_ack    (ext_ack),
    .ext_rnw    (ext_rnw),
    .ext_addr   (ext_addr),
    .ext_be     (ext_be),
    .ext_wdata  (ext_wdata),
    .irq_pulse  (irq_pulse),
    .irq_en     (irq_enable),
    .irq_out    (irq_out)
);

// File: tb/sim_fwd_win_bridge.sv
module sim_fwd_win_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_rnw = 1'b0;
    logic [31:0] host_addr = '0, host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_rdata;
    logic        host_ack, host_err;
    logic        ext_req, ext_rnw;
    logic [7:0]  ext_addr;
    logic [3:0]  ext_be;
    logic [31:0] ext_wdata, ext_rdata;
    logic        ext_ack = 1'b0;
    logic        irq_pulse = 1'b0;
    logic        irq_out;

    int checks = 0, failures = 0, cycles = 0;
    int ext_dly = 0, mcnt = 0, req_rises = 0;
    logic       stab_bad = 1'b0;
    logic [7:0] cap_addr;
    logic [3:0] cap_be;
    logic       cap_rnw;
    logic [31:0] cap_wdata;
    logic m_st = 1'b0, m_en = 1'b0;

    always #4 clk = ~clk;

    fwd_win_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rnw(host_rnw),
        .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ack(host_ack), .host_err(host_err),
        .ext_req(ext_req), .ext_rnw(ext_rnw), .ext_addr(ext_addr), .ext_be(ext_be),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack),
        .irq_pulse(irq_pulse), .irq_out(irq_out)
    );

    function automatic logic [31:0] rd_fn(input logic [7:0] a);
        return {a, ~a, a ^ 8'h5A, 8'hC3};
    endfunction

    assign ext_rdata = rd_fn(ext_addr);

    always @(negedge clk) begin
        if (ext_req) begin
            if (mcnt == 0) begin
                req_rises++;
                cap_addr = ext_addr; cap_be = ext_be; cap_rnw = ext_rnw; cap_wdata = ext_wdata;
            end else if (ext_addr != cap_addr || ext_be != cap_be ||
                         ext_rnw != cap_rnw || ext_wdata != cap_wdata) begin
                stab_bad = 1'b1;
            end
            ext_ack = (mcnt == ext_dly);
            mcnt++;
        end else begin
            ext_ack = 1'b0;
            mcnt = 0;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic access(input logic rnw, input logic [31:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output logic er,
                          output logic got);
        got = 1'b0; rd = '0; er = 1'b0;
        req_rises = 0; stab_bad = 1'b0;
        @(negedge clk);
        host_sel = 1'b1; host_rnw = rnw; host_addr = a; host_be = be; host_wdata = wd;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (host_ack) begin
                got = 1'b1; rd = host_rdata; er = host_err;
                host_sel = 1'b0;
                break;
            end
        end
        host_sel = 1'b0;
        @(negedge clk);
        chk(!host_ack, "R6 ack one cycle", 32'(host_ack), 32'd0);
    endtask

    task automatic remote(input logic rnw, input logic [31:0] a, input logic [3:0] be,
                          input logic [31:0] wd, input int d);
        logic [31:0] rd; logic er, got;
        logic exp_err;
        logic [31:0] exp_rd;
        ext_dly = d;
        access(rnw, a & ~32'h100, be, wd, rd, er, got);
        exp_err = (d >= 16);
        exp_rd  = (exp_err || !rnw) ? 32'd0 : rd_fn({a[7:2], 2'b00});
        chk(got, "R3 ack returned", 32'(got), 32'd1);
        chk(er == exp_err, d == 15 ? "R5 last-cycle ack" : "R4 timeout error",
            32'(er), 32'(exp_err));
        chk(rd == exp_rd, "R3 read data", rd, exp_rd);
        chk(req_rises == 1, "R3 single request", 32'(req_rises), 32'd1);
        chk(cap_addr == {a[7:2], 2'b00}, "R2 R11 ext address", 32'(cap_addr), 32'({a[7:2], 2'b00}));
        chk(cap_be == be && cap_rnw == rnw && (rnw || cap_wdata == wd), "R2 ext fields",
            {cap_be, 27'd0, cap_rnw}, {be, 27'd0, rnw});
        chk(!stab_bad, "R2 fields stable", 32'(stab_bad), 32'd0);
    endtask

    task automatic local_acc(input logic rnw, input logic [31:0] a, input logic [3:0] be,
                             input logic [31:0] wd);
        logic [31:0] rd, exp_rd; logic er, got;
        logic [1:0] o;
        o = a[3:2];
        exp_rd = '0;
        if (rnw && o == 2'd0) exp_rd = {31'd0, m_st};
        if (rnw && o == 2'd1) exp_rd = {31'd0, m_en};
        access(rnw, a | 32'h100, be, wd, rd, er, got);
        if (!rnw && be[3]) begin
            if (o == 2'd1) m_en = wd[0];
            if (o == 2'd2 && wd[0]) m_st = 1'b0;
        end
        chk(got && !er, "R7 local ack", {30'd0, got, er}, 32'd2);
        chk(rd == exp_rd, "R7 local read", rd, exp_rd);
        chk(req_rises == 0, "R7 no ext request", 32'(req_rises), 32'd0);
        chk(irq_out == (m_st & m_en), "R9 R10 irq after write", 32'(irq_out), 32'(m_st & m_en));
    endtask

    task automatic pulse();
        @(negedge clk); irq_pulse = 1'b1;
        @(negedge clk); irq_pulse = 1'b0;
        m_st = 1'b1;
        chk(irq_out == m_en, "R8 irq out", 32'(irq_out), 32'(m_en));
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!ext_req && !host_ack && !host_err && !irq_out, "R1 reset outputs",
            {28'd0, ext_req, host_ack, host_err, irq_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        local_acc(1'b1, 32'h100, 4'hF, 0);
        local_acc(1'b1, 32'h104, 4'hF, 0);

        // directed corners
        remote(1'b1, 32'h0000_00A7, 4'hF, 0, 0);
        remote(1'b1, 32'h0000_0034, 4'h5, 0, 15);
        remote(1'b1, 32'h0000_0034, 4'h5, 0, 16);
        remote(1'b0, 32'h0000_00FF, 4'h9, 32'hDEAD_BEEF, 255);
        remote(1'b0, 32'h0000_0010, 4'h0, 32'h1234_5678, 3);
        pulse();
        local_acc(1'b0, 32'h105, 4'hF, 32'h1);
        local_acc(1'b1, 32'h100, 4'hF, 0);
        local_acc(1'b0, 32'h108, 4'h7, 32'h1);
        local_acc(1'b0, 32'h108, 4'hF, 32'h0);
        local_acc(1'b1, 32'h100, 4'hF, 0);
        local_acc(1'b0, 32'h10B, 4'h8, 32'hFFFF_FF01);
        local_acc(1'b1, 32'h100, 4'hF, 0);
        local_acc(1'b0, 32'h10C, 4'hF, 32'hFFFF_FFFF);
        local_acc(1'b1, 32'h10C, 4'hF, 0);
        local_acc(1'b1, 32'h108, 4'hF, 0);
        local_acc(1'b0, 32'h104, 4'h7, 32'h0);
        local_acc(1'b1, 32'h104, 4'hF, 0);

        for (int n = 0; n < 200; n++) begin
            int kind;
            kind = $urandom_range(0, 9);
            if (kind < 5) begin
                int d;
                d = ($urandom_range(0, 3) == 0) ? $urandom_range(14, 20) : $urandom_range(0, 6);
                remote(1'($urandom_range(0, 1)), $urandom, 4'($urandom_range(0, 15)), $urandom, d);
            end else if (kind < 9) begin
                local_acc(1'($urandom_range(0, 1)), $urandom, 4'($urandom_range(0, 15)),
                          32'($urandom_range(0, 3)));
            end else begin
                pulse();
            end
        end
        finish_run();
    end
endmodule